// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block connects the load/store stage of a 32-bit RISC core to a 32-bit data memory that is addressed by word. For each access it adds the base register to either a second register or a sign-extended 16-bit immediate. The result is the effective address. The block then gives the memory its word address, the byte-lane write enables and store data steered onto the correct lanes. Lanes are numbered big-endian: byte offset 0 is bits 31:24 of the word.

A load is issued in one cycle, and the synchronous memory returns the word in the next cycle. The block keeps the size and byte offset of the outstanding load for that cycle. It then extracts the addressed byte or halfword and zero-extends it to 32 bits. An access that is not aligned to its own size is not split into two accesses. It raises a fault flag and reaches the memory neither as a write nor as a read.

Top module: `be_lsu_aligner`

## Requirements
- R1: In the register form (`req_imm` = 0), the effective address is `req_ra + req_rb` modulo 2^32, and `mem_addr` carries its bits 31:2.
- R2: In the immediate form (`req_imm` = 1), the effective address is `req_ra` plus `req_imm16` sign-extended to 32 bits.
- R3: A byte store (`req_size` = 0) copies `req_rd[7:0]` to all four lanes of `mem_wdata`. It enables only the lane picked by address bits 1:0, with offset 0 giving `mem_we` = 4'b1000 (bits 31:24) and offset 3 giving 4'b0001.
- R4: A halfword store (`req_size` = 1) copies `req_rd[15:0]` to both halves of `mem_wdata`. It enables 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1.
- R5: An aligned word store (`req_size` = 2) sets `mem_we` = 4'b1111 and `mem_wdata` = `req_rd`.
- R6: `misalign` goes high in the same cycle in three cases: a halfword access with address bit 0 set, a word access with address bits 1:0 not zero, or the unused size code 3. While it is high, `mem_we` is 0 and `mem_re` is 0.
- R7: One cycle after an aligned byte load, `load_data` equals the addressed byte of `mem_rdata` (offset 0 is bits 31:24), zero-extended.
- R8: One cycle after an aligned halfword load, `load_data` equals `mem_rdata[31:16]` for address bit 1 = 0, or `mem_rdata[15:0]` for address bit 1 = 1, zero-extended.
- R9: One cycle after an aligned word load, `load_data` equals `mem_rdata`.
- R10: `load_valid` is high exactly in the cycle after `mem_re` was high. It stays low after reset, after stores, after idle cycles and after faulted accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_imm | input | 1 | 1 = base plus immediate, 0 = base plus register |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unused (faults) |
| req_ra | input | 32 | Base register value |
| req_rb | input | 32 | Index register value |
| req_imm16 | input | 16 | Signed immediate offset |
| req_rd | input | 32 | Store data register value |
| mem_addr | output | 30 | Word address (effective address bits 31:2) |
| mem_we | output | 4 | Lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_re | output | 1 | Read strobe for an aligned load |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_re` |
| misalign | output | 1 | Alignment fault for the current request |
| load_valid | output | 1 | `load_data` is valid |
| load_data | output | 32 | Aligned, zero-extended load result |

## Verification
The only internal state is the record of the outstanding load: a valid bit, the size and the byte offset. If the recorded offset is wrong, the wrong byte or halfword appears on `load_data` in the cycle after the read. If the recorded size is wrong, upper bits that should be zero come out non-zero in that same cycle. A stuck valid bit shows on `load_valid` one cycle after a store or an idle cycle. Lane steering faults on the store side have no state behind them. They show on `mem_we` and `mem_wdata` in the request cycle, and they show again through any later load of the same word.

// File: rtl/be_lsu_aligner.sv
module be_lsu_aligner #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic                  req_imm,
  input  logic [1:0]            req_size,
  input  logic [XLEN-1:0]       req_ra,
  input  logic [XLEN-1:0]       req_rb,
  input  logic [IMMW-1:0]       req_imm16,
  input  logic [XLEN-1:0]       req_rd,
  output logic [XLEN-3:0]       mem_addr,
  output logic [XLEN/8-1:0]     mem_we,
  output logic [XLEN-1:0]       mem_wdata,
  output logic                  mem_re,
  input  logic [XLEN-1:0]       mem_rdata,
  output logic                  misalign,
  output logic                  load_valid,
  output logic [XLEN-1:0]       load_data
);
  localparam int LANES = XLEN / 8;
  localparam int OFFW  = $clog2(LANES);

  logic [XLEN-1:0]  ea;
  logic [XLEN-1:0]  operand_b;
  logic [OFFW-1:0]  off;
  logic             access_ok;
  logic [LANES-1:0] lanes;

  logic             pend_v;
  logic [1:0]       pend_sz;
  logic [OFFW-1:0]  pend_off;
  logic [XLEN-1:0]  byte_sh;
  logic [XLEN-1:0]  half_sh;

  assign operand_b = req_imm ? {{(XLEN-IMMW){req_imm16[IMMW-1]}}, req_imm16} : req_rb;
  assign ea        = req_ra + operand_b;
  assign off       = ea[OFFW-1:0];
  assign mem_addr  = ea[XLEN-1:2];

  always_comb begin
    misalign = 1'b0;
    case (req_size)
      2'd0: misalign = 1'b0;
      2'd1: misalign = off[0];
      2'd2: misalign = (off != '0);
      default: misalign = 1'b1;
    endcase
    misalign = misalign & req_valid;
  end

  assign access_ok = req_valid & ~misalign;

  always_comb begin
    case (req_size)
      2'd0:    lanes = {1'b1, {(LANES-1){1'b0}}} >> off;
      2'd1:    lanes = off[1] ? 4'b0011 : 4'b1100;
      2'd2:    lanes = '1;
      default: lanes = '0;
    endcase
  end

  always_comb begin
    case (req_size)
      2'd0:    mem_wdata = {LANES{req_rd[7:0]}};
      2'd1:    mem_wdata = {(LANES/2){req_rd[15:0]}};
      default: mem_wdata = req_rd;
    endcase
  end

  assign mem_we = (access_ok & req_store) ? lanes : '0;
  assign mem_re = access_ok & ~req_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_sz  <= 2'd0;
      pend_off <= '0;
    end else begin
      pend_v <= mem_re;
      if (mem_re) begin
        pend_sz  <= req_size;
        pend_off <= off;
      end
    end
  end

  assign byte_sh = mem_rdata >> {~pend_off, 3'b000};
  assign half_sh = mem_rdata >> (pend_off[1] ? 0 : 16);

  always_comb begin
    load_data = '0;
    if (pend_v) begin
      case (pend_sz)
        2'd0:    load_data = {{(XLEN-8){1'b0}}, byte_sh[7:0]};
        2'd1:    load_data = {{(XLEN-16){1'b0}}, half_sh[15:0]};
        default: load_data = mem_rdata;
      endcase
    end
  end

  assign load_valid = pend_v;
endmodule

// File: rtl/be_lsu_aligner_chk.sv
module be_lsu_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic        req_imm,
  input logic [1:0]  req_size,
  input logic [31:0] req_ra,
  input logic [31:0] req_rb,
  input logic [31:0] req_rd,
  input logic [29:0] mem_addr,
  input logic [3:0]  mem_we,
  input logic [31:0] mem_wdata,
  input logic        mem_re,
  input logic        misalign,
  input logic        load_valid,
  input logic [31:0] load_data
);
  logic [31:0] reg_sum;
  assign reg_sum = req_ra + req_rb;

  a_r1_reg_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_imm) |-> (mem_addr == reg_sum[31:2]));

  a_r3_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'd0) |-> ($countones(mem_we) == 1 && !misalign));

  a_r4_half_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'd1 && !misalign) |->
      (mem_we == 4'b1100 || mem_we == 4'b0011));

  a_r5_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'd2 && !misalign) |->
      (mem_we == 4'b1111 && mem_wdata == req_rd));

  a_r6_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_we == 4'b0000 && !mem_re));

  a_r6_size3_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |-> misalign);

  a_r7_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && req_size == 2'd0) |=> (load_data[31:8] == 24'd0));

  a_r8_half_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && req_size == 2'd1) |=> (load_data[31:16] == 16'd0));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> load_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !load_valid);
endmodule

bind be_lsu_aligner be_lsu_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_imm(req_imm), .req_size(req_size), .req_ra(req_ra), .req_rb(req_rb),
  .req_rd(req_rd), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .mem_re(mem_re), .misalign(misalign), .load_valid(load_valid), .load_data(load_data)
);

// File: tb/sim_be_lsu_aligner.sv
module sim_be_lsu_aligner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_store = 0, req_imm = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_ra = 0, req_rb = 0, req_rd = 0;
  logic [15:0] req_imm16 = 0;
  logic [29:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata, mem_rdata, load_data;
  logic        mem_re, misalign, load_valid;

  be_lsu_aligner u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_imm(req_imm), .req_size(req_size), .req_ra(req_ra), .req_rb(req_rb),
    .req_imm16(req_imm16), .req_rd(req_rd), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .misalign(misalign), .load_valid(load_valid), .load_data(load_data)
  );

  logic [31:0] mem [16];
  always_ff @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
    for (int i = 0; i < 4; i++)
      if (mem_we[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
  end

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        st, im;
    logic [1:0]  sz;
    logic [31:0] ra, rb;
    logic [15:0] imm;
    logic [31:0] rd;
    logic [3:0]  we;
    logic [31:0] wd;
    logic [29:0] addr;
    logic        re, mis;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1,1'b0,2'd0,32'h100,32'h1,16'h0,32'h000000AB,4'b0100,32'hABABABAB,30'h40,1'b0,1'b0},
    '{1'b1,1'b1,2'd0,32'h200,32'h0,16'hFFFF,32'h12345678,4'b0001,32'h78787878,30'h7F,1'b0,1'b0},
    '{1'b1,1'b1,2'd1,32'h10,32'h0,16'h2,32'hDEADBEEF,4'b0011,32'hBEEFBEEF,30'h4,1'b0,1'b0},
    '{1'b1,1'b0,2'd1,32'h20,32'h0,16'h0,32'h0000CAFE,4'b1100,32'hCAFECAFE,30'h8,1'b0,1'b0},
    '{1'b1,1'b0,2'd2,32'hFFFFFFF0,32'h14,16'h0,32'h01020304,4'b1111,32'h01020304,30'h1,1'b0,1'b0},
    '{1'b1,1'b1,2'd1,32'h21,32'h0,16'h0,32'h0,4'b0000,32'h0,30'h8,1'b0,1'b1},
    '{1'b1,1'b0,2'd2,32'h22,32'h0,16'h0,32'h0,4'b0000,32'h0,30'h8,1'b0,1'b1},
    '{1'b0,1'b1,2'd2,32'h40,32'h0,16'h8001,32'h0,4'b0000,32'h0,30'h3FFFE010,1'b0,1'b1},
    '{1'b1,1'b0,2'd3,32'h0,32'h0,16'h0,32'h0,4'b0000,32'h0,30'h0,1'b0,1'b1},
    '{1'b0,1'b0,2'd0,32'h10,32'h3,16'h0,32'h0,4'b0000,32'h0,30'h4,1'b1,1'b0}
  };

  task automatic drive(input logic st, im, input logic [1:0] sz,
                       input logic [31:0] ra, rb, input logic [15:0] imm, input logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_store = st; req_imm = im; req_size = sz;
    req_ra = ra; req_rb = rb; req_imm16 = imm; req_rd = rd;
    #1;
  endtask

  task automatic idle_check_load(input logic [1:0] sz, input logic [31:0] ea,
                                 input logic [31:0] exp, input string tag);
    drive(1'b0, 1'b1, sz, ea, 32'h0, 16'h0, 32'h0);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(load_valid === 1'b1, {tag, " R10 valid"}, {31'b0, load_valid}, 32'h1);
    chk(load_data === exp, tag, load_data, exp);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[12] = 32'hA1B2C3D4;
    repeat (3) @(negedge clk);
    #1;
    chk(load_valid === 1'b0 && mem_we === 4'b0, "R10 reset idle", {27'b0, mem_we, load_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(load_valid === 1'b0, "R10 after reset", {31'b0, load_valid}, 32'h0);

    for (int k = 0; k < 10; k++) begin
      drive(VECS[k].st, VECS[k].im, VECS[k].sz, VECS[k].ra, VECS[k].rb, VECS[k].imm, VECS[k].rd);
      chk(mem_addr === VECS[k].addr, $sformatf("R1/R2 addr vec%0d", k), {2'b0, mem_addr}, {2'b0, VECS[k].addr});
      chk(mem_we === VECS[k].we, $sformatf("R3/R4/R5/R6 we vec%0d", k), {28'b0, mem_we}, {28'b0, VECS[k].we});
      chk(misalign === VECS[k].mis && mem_re === VECS[k].re, $sformatf("R6 fault/re vec%0d", k),
          {30'b0, misalign, mem_re}, {30'b0, VECS[k].mis, VECS[k].re});
      if (VECS[k].we != 4'b0)
        chk(mem_wdata === VECS[k].wd, $sformatf("R3/R4/R5 wdata vec%0d", k), mem_wdata, VECS[k].wd);
    end
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(load_valid === 1'b1, "R10 load vec valid", {31'b0, load_valid}, 32'h1);

    idle_check_load(2'd2, 32'h30, 32'hA1B2C3D4, "R9 word");
    idle_check_load(2'd0, 32'h30, 32'h000000A1, "R7 byte off0");
    idle_check_load(2'd0, 32'h33, 32'h000000D4, "R7 byte off3");
    idle_check_load(2'd0, 32'h31, 32'h000000B2, "R7 byte off1");
    idle_check_load(2'd1, 32'h30, 32'h0000A1B2, "R8 half hi");
    idle_check_load(2'd1, 32'h32, 32'h0000C3D4, "R8 half lo");

    drive(1'b1, 1'b0, 2'd0, 32'h30, 32'h2, 16'h0, 32'hFFFFFF5A);
    @(negedge clk); req_valid = 0; #1;
    chk(load_valid === 1'b0, "R10 no valid after store", {31'b0, load_valid}, 32'h0);
    idle_check_load(2'd2, 32'h30, 32'hA1B25AD4, "R3 byte store lane via readback");

    drive(1'b0, 1'b0, 2'd1, 32'h31, 32'h0, 16'h0, 32'h0);
    @(negedge clk); req_valid = 0; #1;
    chk(load_valid === 1'b0, "R10 R6 no valid after faulted load", {31'b0, load_valid}, 32'h0);

    drive(1'b1, 1'b1, 2'd2, 32'h34, 32'h0, 16'hFFFC, 32'h11223344);
    chk(mem_addr === 30'hC && mem_we === 4'hF, "R2 R5 negative imm word store", {mem_addr, 2'b0}, 32'h30);
    drive(1'b1, 1'b0, 2'd2, 32'h31, 32'h0, 16'h0, 32'hFFFFFFFF);
    @(negedge clk); req_valid = 0; #1;
    idle_check_load(2'd2, 32'h30, 32'h11223344, "R6 faulted store left memory intact");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule